// File: doc/BRIEF.md
# Fractional Clock Divider with Averaging

This block derives a slower clock from its source clock at a ratio that need not be a whole number. The ratio is NUM/DEN, fixed by parameters. With the defaults of 76 and 10 it divides by 7.6. Each output period is a whole number of source cycles. That number is either the floor of the ratio (a short period) or one more (a long period). Over a frame of DEN output periods the lengths add up to exactly NUM source cycles, so the average output frequency is exact even though no single period has the fractional length.

A remainder accumulator picks the length of each period. It adds NUM mod DEN once per period. When the sum reaches DEN, the period is long and DEN is subtracted. Long and short periods are therefore spread evenly through the frame rather than grouped, which keeps the accumulated phase error below one source cycle. Within a period the output is high for the first half of the period, rounded down, and low for the rest, so the duty cycle is near 50% but not exact. A one-cycle `frame_start` pulse marks the first period of every frame.

The reset is synchronous and active high. The first period after reset is period 0 of a frame. Elaboration stops with an error unless NUM > 2·DEN, so that every period has at least one high cycle and one low cycle.

Top module: `frac_clk_div`

## Requirements
- R1: In every cycle after a clock edge at which `rst` is sampled high, `clk_out` and `frame_start` are 0, and the period and frame sequence restarts from period 0.
- R2: Every output period, measured from one rising edge of `clk_out` to the next, lasts either LO = NUM/DEN (integer division) or LO+1 source cycles.
- R3: From one `frame_start` pulse to the next there are exactly NUM source cycles and exactly DEN output periods.
- R4: Each frame contains exactly NUM mod DEN long periods (LO+1 cycles); the rest are short (LO cycles).
- R5: Counting periods from p = 0, the first period after reset, period p is long exactly when floor((p+1)·R/DEN) − floor(p·R/DEN) = 1, with R = NUM mod DEN. This spreads the long periods evenly; for 76/10 the lengths repeat as 7,8,7,8,8.
- R6: In a period of length D, `clk_out` is 1 for the first floor(D/2) source cycles and 0 for the remaining cycles.
- R7: `frame_start` is 1 for exactly one cycle: the first cycle of period 0 of each frame, which recurs every DEN periods. It is then 1 together with `clk_out`.
- R8: The first output period starts in the cycle after the first clock edge at which `rst` is sampled low, so in that cycle both `clk_out` and `frame_start` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_out | output | 1 | Divided clock, high for the first half of each period |
| frame_start | output | 1 | One-cycle pulse at the start of each frame of DEN periods |

## Verification
The bench targets four kinds of mistake:
- **Order of periods.** A design that puts the long periods in the wrong order, or groups them at the end of the frame, still gets the average right. It differs from the expected length sequence within the first frame, and a cycle-by-cycle model of the expected waveform catches that.
- **Miscounted remainder.** An accumulator that compares against the wrong threshold, or drops the subtraction, changes how many long periods fall in a frame. It also moves the gap between frame pulses away from NUM cycles.
- **Wrong high time.** An off-by-one in the high-time comparison gives a high time of floor(D/2)±1. The fast instance (11/5, periods of 2 and 3 cycles) exposes it at once.
- **Reset edges.** Resets arrive at random points mid-period, and every release is checked: a design that resumes the old phase, or starts its first period one cycle late, fails there.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;

    // Per-period event flags passed between the counters.
    typedef struct packed {
        logic is_long;     // current period uses the ceiling length
        logic first_cyc;   // first source cycle of the current period
        logic last_cyc;    // last source cycle of the current period
    } period_ev_t;

    // Width needed to hold values 0..n-1, never below 1.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Short (floor) divide factor.
    function automatic int unsigned short_len(input int unsigned num, input int unsigned den);
        return num / den;
    endfunction

    // Remainder added to the accumulator once per period.
    function automatic int unsigned rem_step(input int unsigned num, input int unsigned den);
        return num % den;
    endfunction

endpackage

// File: rtl/fcd_rem_acc.sv
module fcd_rem_acc
    import frac_clk_div_pkg::*;
#(
    parameter int unsigned NUM = 76,
    parameter int unsigned DEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic step,      // current period ends this cycle
    output logic is_long
);
    localparam int unsigned REM = rem_step(NUM, DEN);
    localparam int unsigned AW  = idx_width(2 * DEN + 1);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;

    assign sum     = acc_q + AW'(REM);
    assign is_long = (sum >= AW'(DEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= is_long ? (sum - AW'(DEN)) : sum;
        end
    end
endmodule

// File: rtl/fcd_period_ctr.sv
module fcd_period_ctr
    import frac_clk_div_pkg::*;
#(
    parameter int unsigned NUM = 76,
    parameter int unsigned DEN = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       live,
    input  logic       is_long,
    output period_ev_t ev,
    output logic       level
);
    localparam int unsigned LO = short_len(NUM, DEN);
    localparam int unsigned CW = idx_width(LO + 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len;
    logic [CW-1:0] half;

    assign len  = is_long ? CW'(LO + 1) : CW'(LO);
    assign half = len >> 1;

    always_comb begin
        ev.is_long   = is_long;
        ev.first_cyc = live && (cnt_q == '0);
        ev.last_cyc  = live && (cnt_q == len - CW'(1));
    end

    assign level = live && (cnt_q < half);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (live) begin
            cnt_q <= (cnt_q == len - CW'(1)) ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/fcd_frame_ctr.sv
module fcd_frame_ctr
    import frac_clk_div_pkg::*;
#(
    parameter int unsigned DEN = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  period_ev_t ev,
    output logic       frame_start
);
    localparam int unsigned PW = idx_width(DEN);

    logic [PW-1:0] pidx_q;

    assign frame_start = ev.first_cyc && (pidx_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pidx_q <= '0;
        end else if (ev.last_cyc) begin
            pidx_q <= (pidx_q == PW'(DEN - 1)) ? '0 : pidx_q + PW'(1);
        end
    end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_clk_div_pkg::*;
#(
    parameter int unsigned NUM = 76,
    parameter int unsigned DEN = 10
) (
    input  logic clk,
    input  logic rst,
    output logic clk_out,
    output logic frame_start
);
    generate
        if (DEN < 1 || NUM <= 2 * DEN) begin : g_bad_ratio
            $error("frac_clk_div: NUM must exceed 2*DEN and DEN must be at least 1");
        end
    endgenerate

    logic       live_q;
    logic       is_long;
    period_ev_t ev;

    // Held low for the first cycle after reset so that every output starts low.
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    fcd_rem_acc #(.NUM(NUM), .DEN(DEN)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step    (ev.last_cyc),
        .is_long (is_long)
    );

    fcd_period_ctr #(.NUM(NUM), .DEN(DEN)) u_period (
        .clk     (clk),
        .rst     (rst),
        .live    (live_q),
        .is_long (is_long),
        .ev      (ev),
        .level   (clk_out)
    );

    fcd_frame_ctr #(.DEN(DEN)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .frame_start (frame_start)
    );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
    import frac_clk_div_pkg::*;
#(
    parameter int unsigned NUM = 76,
    parameter int unsigned DEN = 10
) (
    input logic clk,
    input logic rst,
    input logic clk_out,
    input logic frame_start
);
    localparam int LO  = int'(short_len(NUM, DEN));
    localparam int REM = int'(rem_step(NUM, DEN));

    logic rst_d = 1'b0;
    logic prev_clk;
    logic have_per;
    logic have_frm;
    int   len_cnt;
    int   hi_cnt;
    int   gap_cnt;
    int   per_cnt;
    int   long_cnt;
    logic rise;
    logic closing_long;

    assign rise         = clk_out && !prev_clk;
    assign closing_long = rise && have_per && (len_cnt == LO + 1);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            prev_clk <= 1'b0;
            have_per <= 1'b0;
            have_frm <= 1'b0;
            len_cnt  <= 0;
            hi_cnt   <= 0;
            gap_cnt  <= 0;
            per_cnt  <= 0;
            long_cnt <= 0;
        end else begin
            prev_clk <= clk_out;
            if (rise) begin
                have_per <= 1'b1;
                len_cnt  <= 1;
                hi_cnt   <= 1;
            end else begin
                len_cnt <= len_cnt + 1;
                hi_cnt  <= hi_cnt + (clk_out ? 1 : 0);
            end
            if (frame_start) begin
                have_frm <= 1'b1;
                gap_cnt  <= 1;
                per_cnt  <= 1;
                long_cnt <= 0;
            end else begin
                gap_cnt  <= gap_cnt + 1;
                per_cnt  <= per_cnt + (rise ? 1 : 0);
                long_cnt <= long_cnt + (closing_long ? 1 : 0);
            end
        end
    end

    always @(posedge clk) begin
        if (rst_d) begin
            a_r1_quiet: assert (!clk_out && !frame_start)
                else $error("R1: outputs active right after reset");
        end
        if (!rst && rise && have_per) begin
            a_r2_len: assert (len_cnt == LO || len_cnt == LO + 1)
                else $error("R2: period length %0d", len_cnt);
            a_r6_high: assert (hi_cnt == len_cnt / 2)
                else $error("R6: high %0d of %0d", hi_cnt, len_cnt);
        end
        if (!rst && frame_start && have_frm) begin
            a_r3_frame_len: assert (gap_cnt == NUM && per_cnt == DEN)
                else $error("R3: frame %0d cycles %0d periods", gap_cnt, per_cnt);
            a_r4_long_count: assert (long_cnt + (closing_long ? 1 : 0) == REM)
                else $error("R4: long periods per frame wrong");
        end
    end

    a_r7_single: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    a_r7_on_high: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (clk_out && rise));
endmodule

bind frac_clk_div frac_clk_div_chk #(.NUM(NUM), .DEN(DEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_out     (clk_out),
    .frame_start (frame_start)
);

// File: tb/tb_frac_clk_div.sv
module tb_frac_ref #(
    parameter int NUM = 76,
    parameter int DEN = 10
) (
    input  logic clk,
    input  logic rst,
    output logic exp_clk,
    output logic exp_frame
);
    bit     live = 1'b0;
    longint p    = 0;
    int     off  = 0;

    // Length of period q from the floor-difference rule (R5).
    function automatic int plen(input longint q);
        longint r = longint'(NUM % DEN);
        return NUM / DEN + int'((q + 1) * r / DEN - q * r / DEN);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            live <= 1'b0; p <= 0; off <= 0;
        end else if (!live) begin
            live <= 1'b1;
        end else if (off + 1 == plen(p)) begin
            off <= 0; p <= p + 1;
        end else begin
            off <= off + 1;
        end
    end

    assign exp_clk   = live && (off < plen(p) / 2);
    assign exp_frame = live && (off == 0) && (p % DEN == 0);
endmodule

module tb_frac_clk_div;
    localparam int NA = 76, DA = 10;
    localparam int NB = 11, DB = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_a, frm_a, clk_b, frm_b;
    logic ea_clk, ea_frm, eb_clk, eb_frm;
    int   vectors = 0;
    int   fails   = 0;
    bit   running = 1'b0;
    bit   done    = 1'b0;

    always #10 clk = ~clk;

    frac_clk_div #(.NUM(NA), .DEN(DA)) dut (
        .clk(clk), .rst(rst), .clk_out(clk_a), .frame_start(frm_a));
    frac_clk_div #(.NUM(NB), .DEN(DB)) dut_b (
        .clk(clk), .rst(rst), .clk_out(clk_b), .frame_start(frm_b));

    tb_frac_ref #(.NUM(NA), .DEN(DA)) ref_a (
        .clk(clk), .rst(rst), .exp_clk(ea_clk), .exp_frame(ea_frm));
    tb_frac_ref #(.NUM(NB), .DEN(DB)) ref_b (
        .clk(clk), .rst(rst), .exp_clk(eb_clk), .exp_frame(eb_frm));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle waveform comparison (R1 R5 R6 R7).
    always @(negedge clk) begin
        if (running) begin
            check(clk_a == ea_clk, "R1 R5 R6 clk_out 76/10", int'(clk_a), int'(ea_clk));
            check(frm_a == ea_frm, "R1 R7 frame_start 76/10", int'(frm_a), int'(ea_frm));
            check(clk_b == eb_clk, "R1 R5 R6 clk_out 11/5", int'(clk_b), int'(eb_clk));
            check(frm_b == eb_frm, "R1 R7 frame_start 11/5", int'(frm_b), int'(eb_frm));
        end
    end

    // Period and frame measurement on the 76/10 instance (R2 R3 R4).
    bit prev = 1'b0, have_p = 1'b0, have_f = 1'b0;
    int len = 0, gap = 0, pers = 0, longs = 0;
    always @(negedge clk) begin
        if (running) begin
            if (rst) begin
                prev = 1'b0; have_p = 1'b0; have_f = 1'b0;
            end else begin
                if (clk_a && !prev) begin
                    if (have_p) begin
                        check(len == NA / DA || len == NA / DA + 1, "R2 period length",
                              len, NA / DA);
                        if (len == NA / DA + 1) longs++;
                    end
                    have_p = 1'b1; len = 1; pers++;
                end else begin
                    len++;
                end
                if (frm_a) begin
                    if (have_f) begin
                        check(gap == NA, "R3 cycles per frame", gap, NA);
                        check(pers - 1 == DA, "R3 periods per frame", pers - 1, DA);
                        check(longs == NA % DA, "R4 long periods per frame", longs, NA % DA);
                    end
                    have_f = 1'b1; gap = 1; pers = 1; longs = 0;
                end else begin
                    gap++;
                end
                prev = clk_a;
            end
        end
    end

    task automatic release_and_check();
        rst = 1'b0;
        @(negedge clk);
        check(clk_a && frm_a, "R8 first period 76/10", int'({clk_a, frm_a}), 3);
        check(clk_b && frm_b, "R8 first period 11/5", int'({clk_b, frm_b}), 3);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        running = 1'b1;
        check(!clk_a && !frm_a, "R1 reset state", int'({clk_a, frm_a}), 0);
        release_and_check();
        repeat (400) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            repeat (30 + ($urandom % 500)) @(negedge clk);
            rst = 1'b1;
            repeat (1 + ($urandom % 3)) @(negedge clk);
            check(!clk_a && !frm_a && !clk_b && !frm_b, "R1 outputs low in reset",
                  int'({clk_a, frm_a, clk_b, frm_b}), 0);
            release_and_check();
        end
        repeat (800) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd150000);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule